// File: doc/BRIEF.md
# Eight-Line APB General-Purpose I/O Port

This block is an eight-line I/O port that sits as a slave on an APB bus. Each line reaches its pad through three separate signals: a level from the pad, a level to the pad and an output enable. Software sets the direction of each line and the level it drives. A bank of read-only identification bytes lets boot code recognise the block.

The data register appears at 256 word addresses. The word-address bits double as a per-line mask, so one store or load touches only the lines picked by the address. No read-modify-write sequence is needed. Any line can be handed to an auxiliary hardware port. That port then sets the line's direction and output level, while APB can still read the pin.

The interrupt logic is not part of this block. Its address range is left unmapped and reads as zero.

Top module: `apb_gpio8`

## Requirements
- R1: While presetn is low and in the first cycle after it rises, the data, direction and mode registers are all zero, so every line is an input with pad_oe low and is under software control.
- R2: A write to any data alias (paddr[11:10] == 2'b00) updates only the data bits whose mask bit paddr[k+2] is 1. The other data bits keep their value.
- R3: A read of a data alias returns 0 on every masked-off bit. On an enabled bit it returns the data register bit if the line is a software-controlled output, and the pad_in bit otherwise.
- R4: The direction register sits at offset 0x400. A 1 makes a software-controlled line an output: pad_oe is 1 and pad_out carries the data bit. A 0 makes it an input with pad_oe 0.
- R5: The mode register sits at offset 0x404. A 1 hands the line to the auxiliary port: pad_oe follows aux_oe and pad_out follows aux_out, whatever the direction and data registers hold.
- R6: aux_in always mirrors pad_in. The pin level of a hardware-controlled line stays readable through the data aliases.
- R7: Offsets 0xFF0, 0xFF4, 0xFF8 and 0xFFC read back bytes 0 to 3 of ID_VALUE (default 32'h00475031, byte 0 least significant). Writes there change no register.
- R8: Any other offset reads as zero, and a write to it changes no register.
- R9: Every access completes with zero wait states: pready is 1 in every access phase.
- R10: The direction and mode registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address; bits [9:2] mask data accesses |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data |
| pready | output | 1 | Transfer done (always 1) |
| pad_in | input | 8 | Level seen at each pad |
| pad_out | output | 8 | Level driven to each pad |
| pad_oe | output | 8 | Output enable per pad |
| aux_oe | input | 8 | Direction from the auxiliary port |
| aux_out | input | 8 | Output level from the auxiliary port |
| aux_in | output | 8 | Pad levels returned to the auxiliary port |

## Verification
The assertions check four things on every cycle:
- the reset state of the registers;
- that a masked store never disturbs a masked-off data bit;
- that a masked load returns zero on masked-off lines;
- that writes outside the three writable registers change nothing, and that no pad is enabled unless its direction or mode bit allows it.

Only the bench scenarios show the rest. These are the exact value seen on each line after a mix of software and hardware ownership, the identification bytes, the zero return from unmapped offsets, and the register readback. The bench compares these against a model after each random transfer.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int GPIO_LINES = 8;
    localparam int GPIO_ADDR_W = 12;
    localparam logic [31:0] GPIO_ID_DEFAULT = 32'h0047_5031;

    function automatic logic [7:0] id_byte(input logic [31:0] id, input logic [1:0] k);
        return id[k*8 +: 8];
    endfunction
endpackage

// File: rtl/gpio_apb_regs.sv
module gpio_apb_regs
    import gpio_pkg::*;
#(
    parameter int LINES = GPIO_LINES,
    parameter int ADDR_W = GPIO_ADDR_W,
    parameter logic [31:0] ID_VALUE = GPIO_ID_DEFAULT
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:2] word_addr,
    input  logic [LINES-1:0]  pwdata,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  prdata,
    output logic [LINES-1:0]  data_q,
    output logic [LINES-1:0]  dir_q,
    output logic [LINES-1:0]  mode_q
);
    localparam int DATA_TOP = LINES + 2;
    localparam logic [ADDR_W-1:2] DIR_WORD  = (ADDR_W-2)'(1 << LINES);
    localparam logic [ADDR_W-1:2] MODE_WORD = DIR_WORD + 1'b1;
    localparam logic [ADDR_W-1:4] ID_GROUP  = '1;

    typedef struct packed {
        logic [LINES-1:0] data;
        logic [LINES-1:0] dir;
        logic [LINES-1:0] mode;
    } regs_t;

    regs_t r_d, r_q;
    logic [LINES-1:0] mask, line_view, rdata;
    logic data_hit, dir_hit, mode_hit, id_hit, wr_en, rd_en;

    assign mask     = word_addr[DATA_TOP-1:2];
    assign data_hit = (word_addr[ADDR_W-1:DATA_TOP] == '0);
    assign dir_hit  = (word_addr == DIR_WORD);
    assign mode_hit = (word_addr == MODE_WORD);
    assign id_hit   = (word_addr[ADDR_W-1:4] == ID_GROUP);
    assign wr_en    = psel & penable & pwrite;
    assign rd_en    = psel & ~pwrite;

    // A software-owned output reads back its register bit; any other line reads the pin
    assign line_view = (~r_q.mode & r_q.dir & r_q.data) | (~(~r_q.mode & r_q.dir) & pad_in);

    always_comb begin
        r_d   = r_q;
        rdata = '0;
        if (wr_en) begin
            if (data_hit)      r_d.data = (r_q.data & ~mask) | (pwdata & mask);
            else if (dir_hit)  r_d.dir  = pwdata;
            else if (mode_hit) r_d.mode = pwdata;
        end
        if (rd_en) begin
            if (data_hit)      rdata = line_view & mask;
            else if (dir_hit)  rdata = r_q.dir;
            else if (mode_hit) rdata = r_q.mode;
            else if (id_hit)   rdata = LINES'(id_byte(ID_VALUE, word_addr[3:2]));
        end
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) r_q <= '0;
        else          r_q <= r_d;
    end

    assign prdata = rdata;
    assign data_q = r_q.data;
    assign dir_q  = r_q.dir;
    assign mode_q = r_q.mode;

    assert_reset_clear_R1: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(presetn) |-> (r_q == '0));

    assert_masked_write_R2: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_en && data_hit) |=> (((r_q.data ^ $past(r_q.data)) & ~$past(mask)) == '0));

    assert_masked_read_R3: assert property (@(posedge pclk) disable iff (!presetn)
        (rd_en && data_hit) |-> ((prdata & ~mask) == '0));

    assert_readonly_space_R7: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_en && !data_hit && !dir_hit && !mode_hit) |=> $stable(r_q));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int LINES = gpio_pkg::GPIO_LINES
) (
    input  logic [LINES-1:0] data_q,
    input  logic [LINES-1:0] dir_q,
    input  logic [LINES-1:0] mode_q,
    input  logic [LINES-1:0] aux_oe,
    input  logic [LINES-1:0] aux_out,
    output logic [LINES-1:0] pad_out,
    output logic [LINES-1:0] pad_oe
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_comb begin
            if (mode_q[i]) begin
                pad_out[i] = aux_out[i];
                pad_oe[i]  = aux_oe[i];
            end else begin
                pad_out[i] = data_q[i];
                pad_oe[i]  = dir_q[i];
            end
        end
    end
endmodule

// File: rtl/apb_gpio8.sv
module apb_gpio8
    import gpio_pkg::*;
#(
    parameter int LINES = GPIO_LINES,
    parameter int ADDR_W = GPIO_ADDR_W,
    parameter logic [31:0] ID_VALUE = GPIO_ID_DEFAULT
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [LINES-1:0]  pwdata,
    output logic [LINES-1:0]  prdata,
    output logic              pready,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  pad_oe,
    input  logic [LINES-1:0]  aux_oe,
    input  logic [LINES-1:0]  aux_out,
    output logic [LINES-1:0]  aux_in
);
    logic [LINES-1:0] data_q, dir_q, mode_q;
    logic [1:0] unused_byte_lane;

    assign unused_byte_lane = paddr[1:0];
    assign pready = 1'b1;
    assign aux_in = pad_in;

    gpio_apb_regs #(.LINES(LINES), .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_regs (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .word_addr(paddr[ADDR_W-1:2]), .pwdata(pwdata), .pad_in(pad_in), .prdata(prdata),
        .data_q(data_q), .dir_q(dir_q), .mode_q(mode_q)
    );

    gpio_pad_mux #(.LINES(LINES)) u_mux (
        .data_q(data_q), .dir_q(dir_q), .mode_q(mode_q), .aux_oe(aux_oe),
        .aux_out(aux_out), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // A pad may drive only when its direction bit or its hardware-mode bit allows it
    assert_oe_source_R4: assert property (@(posedge pclk) disable iff (!presetn)
        ((pad_oe & ~(dir_q | mode_q)) == '0));

    assert_hw_owner_R5: assert property (@(posedge pclk) disable iff (!presetn)
        ((pad_oe & mode_q) == (aux_oe & mode_q)));
endmodule

// File: tb/sim_apb_gpio8.sv
module sim_apb_gpio8;
    logic pclk = 1'b0, presetn = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [7:0] pwdata = '0, pad_in = 8'h5A, aux_oe = '0, aux_out = '0;
    logic [7:0] prdata, pad_out, pad_oe, aux_in;
    logic pready;
    int checks = 0, failures = 0;
    logic [7:0] m_data = '0, m_dir = '0, m_mode = '0;
    localparam logic [31:0] ID = 32'h0047_5031;

    always #2 pclk = ~pclk;

    apb_gpio8 u0 (.pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .aux_oe(aux_oe),
        .aux_out(aux_out), .aux_in(aux_in));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_view(input logic [7:0] mask);
        logic [7:0] sw_out = ~m_mode & m_dir;
        return mask & ((sw_out & m_data) | (~sw_out & pad_in));
    endfunction

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge pclk); penable = 1;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
        if (a[11:10] == 2'b00) m_data = (m_data & ~a[9:2]) | (d & a[9:2]);
        else if (a == 12'h400) m_dir = d;
        else if (a == 12'h404) m_mode = d;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge pclk); penable = 1;
        #1; d = prdata;
        check("R9 pready", {7'd0, pready}, 8'h01);
        @(negedge pclk); psel = 0; penable = 0;
    endtask

    task automatic check_pads(input string req);
        #1;
        check({req, " pad_oe"}, pad_oe, (m_mode & aux_oe) | (~m_mode & m_dir));
        check({req, " pad_out"}, pad_out, (m_mode & aux_out) | (~m_mode & m_data));
        check("R6 aux_in", aux_in, pad_in);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge pclk);
        #1 check("R1 pad_oe in reset", pad_oe, 8'h00);
        presetn = 1;
        bus_read(12'h400, rd); check("R1 dir after reset", rd, 8'h00);
        bus_read(12'h404, rd); check("R1 mode after reset", rd, 8'h00);
        bus_read(12'h3FC, rd); check("R1 data reads pins", rd, 8'h5A);

        bus_write(12'h400, 8'hFF);
        bus_read(12'h400, rd); check("R10 dir readback", rd, 8'hFF);
        bus_write(12'h0F << 2, 8'hAA);
        bus_read(12'h3FC, rd); check("R2 masked write low", rd, 8'h0A);
        check_pads("R4");
        bus_write(12'hF0 << 2, 8'hFF);
        bus_read(12'h3C << 2, rd); check("R3 masked read", rd, 8'h38);

        bus_write(12'h404, 8'h0F); aux_oe = 8'h05; aux_out = 8'h03;
        bus_read(12'h404, rd); check("R10 mode readback", rd, 8'h0F);
        check_pads("R5");
        check("R5 pad_oe mix", pad_oe, 8'hF5);
        check("R5 pad_out mix", pad_out, 8'hF3);
        bus_read(12'h3FC, rd); check("R6 hw pin readable", rd, 8'hFA);

        for (int k = 0; k < 4; k++) begin
            bus_read(12'hFF0 + 12'(k * 4), rd); check("R7 id byte", rd, ID[k*8 +: 8]);
        end
        bus_write(12'hFF4, 8'h99);
        bus_read(12'hFF4, rd); check("R7 id read-only", rd, ID[15:8]);
        bus_read(12'h800, rd); check("R8 unmapped zero", rd, 8'h00);
        bus_write(12'h800, 8'hFF); bus_write(12'h408, 8'hFF);
        bus_read(12'h400, rd); check("R8 dir untouched", rd, m_dir);
        bus_read(12'h404, rd); check("R8 mode untouched", rd, m_mode);
        bus_read(12'h3FC, rd); check("R8 data untouched", rd, exp_view(8'hFF));
        check_pads("R8");

        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 5);
            pad_in = 8'($urandom); aux_oe = 8'($urandom); aux_out = 8'($urandom);
            case (op)
                0, 1: bus_write({2'b00, 8'($urandom), 2'b00}, 8'($urandom));
                2: bus_write(12'h400, 8'($urandom));
                3: bus_write(12'h404, 8'($urandom));
                default: begin
                    logic [7:0] m = 8'($urandom);
                    bus_read({2'b00, m, 2'b00}, rd);
                    check("R3 random read", rd, exp_view(m));
                end
            endcase
            check_pads("R4/R5 random");
        end
        finish_run();
    end
endmodule